// File: doc/BRIEF.md
# Clock Frequency-Select Watchdog Controller

This block chooses the five-bit frequency-select code that a clock synthesizer's divider network uses. At power-up, the shared strap pins carry the board's hardware code and a two-bit output-current multiplier. The block captures them during the first cycle in which the active-low power-good input is low. After that capture it locks, and it raises a mode flag that hands the pins over to their clock-output role. Later activity on power-good or on the pins has no effect until the next power-up reset.

Software reaches the block through a small register port with a synchronous write and a combinational read. Through that port it can:
- program an alternative select code;
- choose whether that code is used in normal operation;
- set a watchdog limit, counted in prescaled reference ticks;
- enable the watchdog;
- choose which code the watchdog falls back to;
- restart the watchdog by writing a kick address.

If the watchdog is not kicked within the limit, the active code switches to the chosen fallback. The block also drives an open-drain system reset, modelled as an active-low output-enable. It pulses this reset after a watchdog timeout and after any change of the active code once the straps are locked.

Three state machines do the work:
- The strap machine starts in SP_WAIT and goes to SP_LOCKED on the first power-good low. It never leaves SP_LOCKED.
- The watchdog machine starts in WD_OFF. It goes to WD_RUN when the straps are locked and the watchdog is enabled. From WD_RUN it goes to WD_EXPIRED when the limit is reached on a tick. A kick takes WD_EXPIRED back to WD_RUN. Losing the enable or the lock returns either state to WD_OFF.
- The reset-pulse machine goes from RP_IDLE to RP_PULSE on a trigger. A further trigger in RP_PULSE restarts the pulse. It returns to RP_IDLE when its tick count runs out.

Top module: `clkcfg_wdog_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it, `sel_fs` and `sel_mult` are 0, `strap_outputs` is 0 and `rst_oe_n` is 1. The register reads return 0 at the control address (0), at the software-code address (1) and at the strap address (4). The limit address (2) returns `WD_LIMIT_RST`.
- R2: While `pwrgd_n` is high, the strap pins are not sampled. In the first clock in which `pwrgd_n` is low, `strap_fs` and `strap_mult` are latched and `strap_outputs` becomes 1. Address 4 then reads `{mult, fs}`, with fs in bits 4:0 and mult in bits 6:5.
- R3: Once the straps are locked, changes on `pwrgd_n`, `strap_fs` and `strap_mult` change neither the latched values nor `strap_outputs` until `rst_n` is asserted.
- R4: The control register is at address 0. Bit 0 selects the software code, bit 1 enables the watchdog and bit 2 selects the fallback (1 = software, 0 = hardware). The software code is at address 1, bits 4:0. When the watchdog has not expired, `sel_fs` is the software code if bit 0 is set and the latched strap code otherwise. `sel_fs` follows a write two clocks later.
- R5: The watchdog does not count while control bit 1 is 0. It is held cleared while the straps are not locked.
- R6: With the watchdog enabled, reaching the limit at address 2 in ticks with no kick expires it. `sel_fs` then takes the software code if control bit 2 is set and the strap code otherwise.
- R7: A write to the kick address (3) restarts the count and leaves the expired state, so `sel_fs` returns to the normal selection. Regular kicks within the limit prevent a timeout.
- R8: A timeout drives `rst_oe_n` low for `PULSE_TICKS` ticks, give or take one tick. This happens even when the active code does not change.
- R9: After lock, any change of `sel_fs` caused by a register write starts a reset pulse. A write that leaves `sel_fs` unchanged starts none, and the strap capture itself starts none.
- R10: A trigger during a pulse restarts the full pulse width.
- R11: The control register reads back all eight bits as written; bits 7:3 have no effect. The software code reads back with bits 7:5 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| pwrgd_n | input | 1 | Active-low power-good strobe that qualifies the straps |
| strap_fs | input | FS_W | Frequency-select strap pins |
| strap_mult | input | MULT_W | Current-multiplier strap pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| sel_fs | output | FS_W | Active frequency-select code sent to the divider network |
| sel_mult | output | MULT_W | Latched current-multiplier code |
| strap_outputs | output | 1 | 1 once sampling is done and the strap pins act as clock outputs |
| rst_oe_n | output | 1 | Active-low enable of the open-drain system reset pull-down |

## Verification
Several properties are checked every cycle. The strap lock is sticky and the captured values stay frozen. The watchdog is held off while the straps are unlocked, and an expiry happens only on a tick. Every trigger pulls the reset low on the next clock, and the pulse counter stays within its bounds. Every post-lock change of the active code coincides with a low reset. Only the bench scenarios can show the end-to-end behaviour: that the timeout arrives after the programmed number of ticks, which fallback code appears, the actual pulse width and its restart, and that power-good activity after lock and writes that leave the code unchanged have no effect.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SWFS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd2;
    localparam logic [ADDR_W-1:0] A_KICK  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STRAP = 3'd4;

    localparam int CB_SWUSE = 0;
    localparam int CB_WDEN  = 1;
    localparam int CB_FBSW  = 2;

    typedef enum logic       {SP_WAIT, SP_LOCKED}          strap_st_e;
    typedef enum logic [1:0] {WD_OFF, WD_RUN, WD_EXPIRED}  wd_st_e;
    typedef enum logic       {RP_IDLE, RP_PULSE}           rp_st_e;
endpackage

// File: rtl/clkcfg_tick.sv
module clkcfg_tick #(
    parameter int PRESCALE = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/clkcfg_strap.sv
module clkcfg_strap
    import clkcfg_pkg::*;
#(
    parameter int FS_W   = 5,
    parameter int MULT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_n,
    input  logic [FS_W-1:0]   fs_pin,
    input  logic [MULT_W-1:0] mult_pin,
    output logic              locked,
    output logic [FS_W-1:0]   fs_q,
    output logic [MULT_W-1:0] mult_q
);
    strap_st_e st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SP_WAIT;
            fs_q   <= '0;
            mult_q <= '0;
        end else begin
            st <= st_nxt;
            if (st == SP_WAIT && !pg_n) begin
                fs_q   <= fs_pin;
                mult_q <= mult_pin;
            end
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SP_WAIT:   if (!pg_n) st_nxt = SP_LOCKED;
            SP_LOCKED: st_nxt = SP_LOCKED;
        endcase
    end

    always_comb locked = (st == SP_LOCKED);

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(fs_q) && $stable(mult_q)));
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !pg_n) |=> (locked && fs_q == $past(fs_pin) && mult_q == $past(mult_pin)));
endmodule

// File: rtl/clkcfg_wdog.sv
module clkcfg_wdog
    import clkcfg_pkg::*;
#(
    parameter int WD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            locked,
    input  logic            enable,
    input  logic            tick,
    input  logic            kick,
    input  logic [WD_W-1:0] limit,
    output logic            expired,
    output logic            timeout_evt
);
    wd_st_e st, st_nxt;
    logic [WD_W-1:0] cnt;
    logic [WD_W:0]   cnt_inc;
    logic            hit;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign hit     = tick && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= WD_OFF;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st == WD_RUN && st_nxt == WD_RUN && !kick) begin
                if (tick) cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            WD_OFF:     if (locked && enable) st_nxt = WD_RUN;
            WD_RUN:     if (!locked || !enable) st_nxt = WD_OFF;
                        else if (kick)          st_nxt = WD_RUN;
                        else if (hit)           st_nxt = WD_EXPIRED;
            WD_EXPIRED: if (!locked || !enable) st_nxt = WD_OFF;
                        else if (kick)          st_nxt = WD_RUN;
            default:    st_nxt = WD_OFF;
        endcase
    end

    always_comb begin
        expired     = (st == WD_EXPIRED);
        timeout_evt = (st == WD_RUN) && (st_nxt == WD_EXPIRED);
    end

    p_off_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked || !enable) |=> (st == WD_OFF));
    p_expire_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_EXPIRED && $past(st) == WD_RUN) |-> $past(tick));
    p_kick_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && locked && enable && st != WD_OFF) |=> (st == WD_RUN && cnt == '0));
endmodule

// File: rtl/clkcfg_rstpulse.sv
module clkcfg_rstpulse
    import clkcfg_pkg::*;
#(
    parameter int PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic tick,
    output logic rst_oe_n
);
    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    rp_st_e st, st_nxt;
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RP_IDLE;
            left <= '0;
        end else begin
            st <= st_nxt;
            if (trig)                     left <= FULL;
            else if (st == RP_PULSE && tick) left <= left - 1'b1;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RP_IDLE:  if (trig) st_nxt = RP_PULSE;
            RP_PULSE: if (trig)                        st_nxt = RP_PULSE;
                      else if (tick && left == ONE)    st_nxt = RP_IDLE;
        endcase
    end

    always_comb rst_oe_n = (st != RP_PULSE);

    p_trig_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !rst_oe_n);
    p_left_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RP_PULSE) |-> (left != '0 && left <= FULL));
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_oe_n) |-> ($past(tick) && !$past(trig)));
endmodule

// File: rtl/clkcfg_wdog_ctrl.sv
module clkcfg_wdog_ctrl
    import clkcfg_pkg::*;
#(
    parameter int              FS_W         = 5,
    parameter int              MULT_W       = 2,
    parameter int              WD_W         = 8,
    parameter int              PRESCALE     = 8,
    parameter int              PULSE_TICKS  = 16,
    parameter logic [WD_W-1:0] WD_LIMIT_RST = 8'd200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrgd_n,
    input  logic [FS_W-1:0]   strap_fs,
    input  logic [MULT_W-1:0] strap_mult,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [FS_W-1:0]   sel_fs,
    output logic [MULT_W-1:0] sel_mult,
    output logic              strap_outputs,
    output logic              rst_oe_n
);
    logic              tick, locked, locked_d, expired, timeout_evt, kick, chg, trig;
    logic [FS_W-1:0]   hw_fs, swfs_q, nxt_fs, sel_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [WD_W-1:0]   limit_q;

    clkcfg_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    clkcfg_strap #(.FS_W(FS_W), .MULT_W(MULT_W)) u_strap (
        .clk(clk), .rst_n(rst_n), .pg_n(pwrgd_n), .fs_pin(strap_fs),
        .mult_pin(strap_mult), .locked(locked), .fs_q(hw_fs), .mult_q(sel_mult));

    assign kick = reg_we && (reg_addr == A_KICK);

    clkcfg_wdog #(.WD_W(WD_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .locked(locked), .enable(ctrl_q[CB_WDEN]),
        .tick(tick), .kick(kick), .limit(limit_q), .expired(expired),
        .timeout_evt(timeout_evt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            swfs_q  <= '0;
            limit_q <= WD_LIMIT_RST;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL:  ctrl_q  <= reg_wdata;
                A_SWFS:  swfs_q  <= reg_wdata[FS_W-1:0];
                A_LIMIT: limit_q <= reg_wdata[WD_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_SWFS:  reg_rdata = DATA_W'(swfs_q);
            A_LIMIT: reg_rdata = DATA_W'(limit_q);
            A_STRAP: reg_rdata = DATA_W'({sel_mult, hw_fs});
            default: reg_rdata = '0;
        endcase
    end

    always_comb begin
        if (expired) nxt_fs = ctrl_q[CB_FBSW]  ? swfs_q : hw_fs;
        else         nxt_fs = ctrl_q[CB_SWUSE] ? swfs_q : hw_fs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            locked_d <= 1'b0;
        end else begin
            sel_q    <= nxt_fs;
            locked_d <= locked;
        end
    end

    assign chg           = locked_d && (sel_q != nxt_fs);
    assign trig          = timeout_evt || chg;
    assign sel_fs        = sel_q;
    assign strap_outputs = locked;

    clkcfg_rstpulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(trig), .tick(tick), .rst_oe_n(rst_oe_n));

    p_chg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_d && $past(locked_d) && sel_q != $past(sel_q)) |-> !rst_oe_n);
    p_mode_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_outputs) |-> !$past(pwrgd_n));
endmodule

// File: tb/clkcfg_wdog_ctrl_tb.sv
module clkcfg_wdog_ctrl_tb;
    localparam int P  = 4;
    localparam int PT = 16;

    logic       clk = 1'b0;
    logic       rst_n, pwrgd_n, reg_we;
    logic [4:0] strap_fs;
    logic [1:0] strap_mult;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [4:0] sel_fs;
    logic [1:0] sel_mult;
    logic       strap_outputs, rst_oe_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    clkcfg_wdog_ctrl #(.PRESCALE(P), .PULSE_TICKS(PT)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_fs(strap_fs),
        .strap_mult(strap_mult), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_fs(sel_fs),
        .sel_mult(sel_mult), .strap_outputs(strap_outputs), .rst_oe_n(rst_oe_n));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [4:0] exp_sel(input bit exp, input logic [2:0] c,
                                           input logic [4:0] sw, input logic [4:0] hw);
        if (exp) return c[2] ? sw : hw;
        return c[0] ? sw : hw;
    endfunction

    task automatic wait_low(input string tag);
        for (int i = 0; i < 8; i++) begin
            if (!rst_oe_n) return;
            cyc(1);
        end
        chk(rst_oe_n, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0]  d;
        logic [31:0] seed;
        logic [4:0]  hw, msw, old;
        logic [2:0]  mctl;
        seed = $urandom(32'h5EED1234);
        rst_n = 0; pwrgd_n = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        strap_fs = 5'h0A; strap_mult = 2'b01;
        cyc(3);
        // R1 reset state
        chk(sel_fs, 5'h00, "R1 sel_fs");
        chk(strap_outputs, 1'b0, "R1 strap_outputs");
        chk(rst_oe_n, 1'b1, "R1 rst_oe_n");
        rd(3'd2, d); chk(d, 8'd200, "R1 limit");
        rd(3'd0, d); chk(d, 8'h00, "R1 ctrl");
        @(negedge clk); rst_n = 1;
        cyc(3);
        strap_fs = 5'h13; strap_mult = 2'b10;
        cyc(3);
        // R2 no sampling while power-good high
        rd(3'd4, d); chk(d, 8'h00, "R2 strap before pg");
        chk(strap_outputs, 1'b0, "R2 mode before pg");
        pwrgd_n = 0;
        cyc(1);
        chk(strap_outputs, 1'b1, "R2 mode after pg");
        rd(3'd4, d); chk(d, 8'h53, "R2 strap capture");
        cyc(2);
        hw = 5'h13;
        chk(sel_fs, hw, "R4 hw code");
        chk(sel_mult, 2'b10, "R2 mult");
        chk(rst_oe_n, 1'b1, "R9 no pulse at lock");
        // R3 later power-good and pin activity ignored
        pwrgd_n = 1; strap_fs = 5'h07; strap_mult = 2'b00; cyc(3);
        pwrgd_n = 0; cyc(3);
        rd(3'd4, d); chk(d, 8'h53, "R3 strap frozen");
        chk(sel_fs, hw, "R3 sel frozen");
        chk(strap_outputs, 1'b1, "R3 mode frozen");
        // R11 readback
        wr(3'd1, 8'hFF); rd(3'd1, d); chk(d, 8'h1F, "R11 swfs mask");
        wr(3'd0, 8'hF8); rd(3'd0, d); chk(d, 8'hF8, "R11 ctrl byte");
        cyc(3); chk(sel_fs, hw, "R11 spare bits no effect");
        mctl = 3'b000; msw = 5'h1F;
        // R4 / R9 random selections with watchdog off
        for (int it = 0; it < 20; it++) begin
            old = exp_sel(0, mctl, msw, hw);
            msw  = 5'($urandom);
            mctl = {1'($urandom), 1'b0, 1'($urandom)};
            wr(3'd1, {3'b000, msw});
            wr(3'd0, {5'b00000, mctl});
            cyc(1);
            chk(sel_fs, exp_sel(0, mctl, msw, hw), "R4 random select");
            if (sel_fs != old) chk(rst_oe_n, 1'b0, "R9 pulse on change");
            cyc((PT + 2) * P);
            chk(rst_oe_n, 1'b1, "R8 pulse ended");
        end
        // R9 write that keeps code: no pulse
        wr(3'd0, 8'h00); cyc((PT + 2) * P);
        wr(3'd1, 8'h05); cyc(3);
        chk(rst_oe_n, 1'b1, "R9 unchanged code no pulse");
        // R8 pulse width
        wr(3'd0, 8'h01); wait_low("R9 change pulse");
        cyc((PT - 2) * P); chk(rst_oe_n, 1'b0, "R8 still low");
        cyc(3 * P);        chk(rst_oe_n, 1'b1, "R8 released");
        // R10 retrigger
        wr(3'd0, 8'h00); wait_low("R10 first pulse");
        cyc(8 * P);
        wr(3'd0, 8'h01);
        cyc(12 * P);       chk(rst_oe_n, 1'b0, "R10 restarted width");
        cyc(8 * P);        chk(rst_oe_n, 1'b1, "R10 released");
        // R5 disabled watchdog never expires
        wr(3'd2, 8'd10);
        cyc(40 * P); chk(sel_fs, 5'h05, "R5 disabled no timeout");
        // R6 / R7 hardware fallback
        wr(3'd0, 8'h03); wr(3'd3, 8'h00);
        cyc(8 * P); chk(sel_fs, 5'h05, "R7 before limit");
        wr(3'd3, 8'h00);
        cyc(8 * P); chk(sel_fs, 5'h05, "R7 kicks prevent timeout");
        cyc(4 * P);
        chk(sel_fs, hw, "R6 hw fallback");
        chk(rst_oe_n, 1'b0, "R8 timeout pulse");
        wr(3'd3, 8'h00); cyc(1);
        chk(sel_fs, 5'h05, "R7 kick restores");
        // R6 software fallback, R8 pulse without code change
        cyc((PT + 2) * P);
        wr(3'd0, 8'h07); wr(3'd3, 8'h00);
        cyc(12 * P);
        chk(sel_fs, 5'h05, "R6 sw fallback");
        chk(rst_oe_n, 1'b0, "R8 timeout pulse same code");
        wr(3'd0, 8'h01); cyc(20 * P);
        chk(sel_fs, 5'h05, "R7 disable clears expiry");
        // R5 watchdog held while unlocked, R1 after reset
        @(negedge clk); rst_n = 0; pwrgd_n = 1; strap_fs = 5'h11; strap_mult = 2'b11;
        cyc(2); rst_n = 1; cyc(2);
        rd(3'd4, d); chk(d, 8'h00, "R1 strap cleared by reset");
        wr(3'd1, 8'h05); wr(3'd2, 8'd2); wr(3'd0, 8'h06);
        cyc(20 * P);
        chk(sel_fs, 5'h00, "R5 no timeout before lock");
        pwrgd_n = 0; cyc(3);
        chk(sel_fs, 5'h11, "R2 new strap after reset");
        cyc(6 * P);
        chk(sel_fs, 5'h05, "R6 timeout after lock");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule